// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Receive FIFO

This block is the receive side of a start-stop serial port. It watches a single serial input line, finds start bits, and assembles characters in one of eight run-time formats. A format is built from three choices: 7 or 8 data bits, 1 or 2 stop bits, and even, odd or no parity. Each finished character goes into a 16-entry receive queue. The character's own parity-error and framing-error bits are stored with it in the same entry.

Software reads the queue through a show-ahead read port. The head entry is always visible on the read outputs, and a one-cycle pop strobe removes it. Two sticky flags report overrun and break, and one clear strobe resets both. The synchronized level of the serial line is also available, so that software can confirm a break after a framing error.

Bit timing comes from a 16x oversampling tick. That tick is made either by an internal programmable divider or from rising edges on an external clock input.

Top module: `serial_rx_fifo`

## Requirements
- R1: Data bits are taken least significant bit first. With `cfg_len7`=1 the character holds 7 data bits and `rd_data[7]` reads 0. With `cfg_len7`=0 it holds 8 data bits.
- R2: With `cfg_par_en`=1 one parity bit follows the data bits. `cfg_par_odd`=0 selects even parity and `cfg_par_odd`=1 selects odd parity. A mismatch sets `rd_perr` for that entry. With `cfg_par_en`=0 no parity bit is expected and `rd_perr` is 0.
- R3: The receiver samples 1 stop bit, or 2 stop bits when `cfg_stop2`=1. If any stop sample is low, `rd_ferr` is set for that entry. The character is still stored.
- R4: A start bit is accepted only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit produces no entry.
- R5: The receive queue holds up to 16 entries. `rd_count` gives the number of entries. `rd_valid` is high whenever the queue is not empty, and the head entry is shown in arrival order. `rd_pop` removes the head entry. `rd_pop` on an empty queue has no effect.
- R6: If a character completes while the queue holds 16 entries, that character is discarded, the stored entries are kept, and `ovr_flag` goes high. `ovr_flag` stays high until `flag_clr` is pulsed.
- R7: `brk_flag` is set when a character that had a framing error is followed by a character whose samples are all low: the data bits, the parity bit and every stop bit. A framing error followed by a normal character does not set it. `brk_flag` stays high until `flag_clr` is pulsed.
- R8: `rxd_level` shows `rxd_in` after two clock stages of synchronization.
- R9: With `cfg_ext_clk`=0 the oversampling tick fires every `cfg_baud_div`+1 clocks. With `cfg_ext_clk`=1 the tick fires once per rising edge of `ext_clk_in`, after that input is synchronized. One bit time is 16 ticks.
- R10: After reset the queue is empty, `ovr_flag` and `brk_flag` are 0, and `rxd_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_ext_clk | input | 1 | 1: oversampling tick from ext_clk_in |
| cfg_baud_div | input | 16 | Internal divider; tick every value+1 clocks |
| ext_clk_in | input | 1 | External 16x bit clock |
| rxd_in | input | 1 | Serial data line, idle high |
| rd_pop | input | 1 | Remove head entry |
| flag_clr | input | 1 | Clear overrun and break flags |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_valid | output | 1 | Queue not empty |
| rd_count | output | 5 | Number of stored entries |
| ovr_flag | output | 1 | Sticky overrun |
| brk_flag | output | 1 | Sticky break |
| rxd_level | output | 1 | Synchronized serial line level |

## Verification
A character reaches the queue one clock after the middle of its last stop bit. Counting from the falling edge of the start bit, that is about ten-sixteenths of a bit into the last stop bit, and it includes the two-stage synchronizer. The bench therefore reads the head entry only after it has driven the full frame and two idle bit times. After that point the sampling phase and the tick phase cannot change the outcome. `rxd_level` is due two clocks after a change on `rxd_in`, and the bench samples it three falling edges later. Each pop is followed by a check of the count on the next falling clock edge, after the one register update has taken place.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int OVS   = 16;
    localparam int OVS_W = $clog2(OVS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_entry_t;

    typedef struct packed {
        logic len7;
        logic stop2;
        logic par_en;
        logic par_odd;
    } rx_fmt_t;

    // Returns 1 when the data bits and the parity bit disagree with the chosen sense
    function automatic logic parity_bad(input logic [7:0] d, input logic pbit, input logic odd);
        return (^d) ^ pbit ^ odd;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
    parameter int DIV_W = 16,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             use_ext,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_clk,
    output logic             tick
);
    logic [DIV_W-1:0] div_cnt;
    logic             int_tick;
    logic             ext_s;
    logic             ext_d;
    logic             ext_tick;

    assign int_tick = (div_cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)           div_cnt <= '0;
        else if (int_tick) div_cnt <= '0;
        else               div_cnt <= div_cnt + 1'b1;
    end

    srx_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_ext_sync (
        .clk(clk), .rst(rst), .d(ext_clk), .q(ext_s)
    );

    always_ff @(posedge clk) begin
        if (rst) ext_d <= 1'b0;
        else     ext_d <= ext_s;
    end

    assign ext_tick = ext_s & ~ext_d;
    assign tick     = use_ext ? ext_tick : int_tick;
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  rx_fmt_t   fmt,
    output logic      out_vld,
    output rx_entry_t out_entry,
    output logic      out_all_low
);
    rx_state_e        st;
    logic [OVS_W-1:0] cnt;
    logic [2:0]       idx;
    logic [7:0]       shreg;
    logic             pbit;
    logic             stop_bad;
    logic             stop_low;
    logic             second;
    logic             mid_bit;
    logic             last_idx;

    assign mid_bit  = (cnt == OVS_W'(OVS - 1));
    assign last_idx = (idx == (fmt.len7 ? 3'd6 : 3'd7));

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            idx         <= '0;
            shreg       <= '0;
            pbit        <= 1'b0;
            stop_bad    <= 1'b0;
            stop_low    <= 1'b1;
            second      <= 1'b0;
            out_vld     <= 1'b0;
            out_entry   <= '0;
            out_all_low <= 1'b0;
        end else begin
            out_vld <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: begin
                        if (!rxd) begin
                            st  <= ST_START;
                            cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == OVS_W'(OVS / 2 - 1)) begin
                            cnt <= '0;
                            if (!rxd) begin
                                st       <= ST_DATA;
                                idx      <= '0;
                                shreg    <= '0;
                                pbit     <= 1'b0;
                                stop_bad <= 1'b0;
                                stop_low <= 1'b1;
                                second   <= 1'b0;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (mid_bit) begin
                            cnt        <= '0;
                            shreg[idx] <= rxd;
                            idx        <= idx + 1'b1;
                            if (last_idx) st <= fmt.par_en ? ST_PAR : ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (mid_bit) begin
                            cnt  <= '0;
                            pbit <= rxd;
                            st   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (mid_bit) begin
                            cnt <= '0;
                            if (fmt.stop2 && !second) begin
                                second   <= 1'b1;
                                stop_bad <= !rxd;
                                stop_low <= !rxd;
                            end else begin
                                st             <= ST_IDLE;
                                out_vld        <= 1'b1;
                                out_entry.data <= shreg;
                                out_entry.perr <= fmt.par_en && parity_bad(shreg, pbit, fmt.par_odd);
                                out_entry.ferr <= stop_bad | !rxd;
                                out_all_low    <= (shreg == 8'd0) && !(fmt.par_en && pbit)
                                                  && stop_low && !rxd;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t din,
    input  logic      pop,
    output rx_entry_t dout,
    output logic      full,
    output logic [CW-1:0] count
);
    rx_entry_t   mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic        do_push;
    logic        do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
    import srx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DEPTH = 16,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_len7,
    input  logic             cfg_stop2,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_ext_clk,
    input  logic [DIV_W-1:0] cfg_baud_div,
    input  logic             ext_clk_in,
    input  logic             rxd_in,
    input  logic             rd_pop,
    input  logic             flag_clr,
    output logic [7:0]       rd_data,
    output logic             rd_perr,
    output logic             rd_ferr,
    output logic             rd_valid,
    output logic [$clog2(DEPTH+1)-1:0] rd_count,
    output logic             ovr_flag,
    output logic             brk_flag,
    output logic             rxd_level
);
    rx_fmt_t   fmt;
    logic      tick;
    logic      rxd_s;
    logic      char_vld;
    rx_entry_t char_entry;
    logic      char_all_low;
    rx_entry_t head;
    logic      q_full;
    logic      prev_ferr;

    assign fmt = {cfg_len7, cfg_stop2, cfg_par_en, cfg_par_odd};

    srx_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_rxd_sync (
        .clk(clk), .rst(rst), .d(rxd_in), .q(rxd_s)
    );

    srx_tick_gen #(.DIV_W(DIV_W), .SYNC(SYNC)) u_tick (
        .clk(clk), .rst(rst), .use_ext(cfg_ext_clk), .div(cfg_baud_div),
        .ext_clk(ext_clk_in), .tick(tick)
    );

    srx_framer u_framer (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd_s), .fmt(fmt),
        .out_vld(char_vld), .out_entry(char_entry), .out_all_low(char_all_low)
    );

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(char_vld), .din(char_entry), .pop(rd_pop),
        .dout(head), .full(q_full), .count(rd_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_flag  <= 1'b0;
            brk_flag  <= 1'b0;
            prev_ferr <= 1'b0;
        end else begin
            if (flag_clr) begin
                ovr_flag <= 1'b0;
                brk_flag <= 1'b0;
            end
            if (char_vld) begin
                prev_ferr <= char_entry.ferr;
                if (q_full)                   ovr_flag <= 1'b1;
                if (prev_ferr && char_all_low) brk_flag <= 1'b1;
            end
        end
    end

    assign rd_valid  = (rd_count != '0);
    assign rd_data   = head.data;
    assign rd_perr   = head.perr;
    assign rd_ferr   = head.ferr;
    assign rxd_level = rxd_s;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DEPTH = 16,
    parameter int SYNC  = 2
) (
    input logic       clk,
    input logic       rst,
    input logic [$clog2(DEPTH+1)-1:0] rd_count,
    input logic       rd_pop,
    input logic       flag_clr,
    input logic       ovr_flag,
    input logic       brk_flag,
    input logic       rxd_in,
    input logic       rxd_level,
    input logic       cfg_len7,
    input logic       char_vld,
    input logic [7:0] char_data
);
    logic [3:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= '0;
        else if (since_rst != 4'hF) since_rst <= since_rst + 1'b1;
    end

    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        rd_count <= ($clog2(DEPTH+1))'(DEPTH));

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && rd_count == '0) |=> (rd_count <= 1));

    p_ovr_when_full_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> ($past(rd_count) == ($clog2(DEPTH+1))'(DEPTH)));

    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !flag_clr) |=> ovr_flag);

    p_brk_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (brk_flag && !flag_clr) |=> brk_flag);

    p_len7_msb_r1: assert property (@(posedge clk) disable iff (rst)
        (char_vld && cfg_len7) |-> !char_data[7]);

    p_level_delay_r8: assert property (@(posedge clk) disable iff (rst)
        (since_rst > 4'(SYNC + 1)) |-> (rxd_level == $past(rxd_in, SYNC)));
endmodule

bind serial_rx_fifo srx_checker #(.DEPTH(DEPTH), .SYNC(SYNC)) u_chk (
    .clk(clk), .rst(rst), .rd_count(rd_count), .rd_pop(rd_pop), .flag_clr(flag_clr),
    .ovr_flag(ovr_flag), .brk_flag(brk_flag), .rxd_in(rxd_in), .rxd_level(rxd_level),
    .cfg_len7(cfg_len7), .char_vld(char_vld), .char_data(char_entry.data)
);

// File: tb/serial_rx_fifo_bench.sv
module serial_rx_fifo_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_len7 = 1'b0, cfg_stop2 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic        cfg_ext_clk = 1'b0;
    logic [15:0] cfg_baud_div = 16'd0;
    logic        ext_clk_in = 1'b0;
    logic        rxd_in = 1'b1;
    logic        rd_pop = 1'b0;
    logic        flag_clr = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_perr, rd_ferr, rd_valid, ovr_flag, brk_flag, rxd_level;
    logic [4:0]  rd_count;

    int checks = 0;
    int errors = 0;
    int bit_clks = 16;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always #20 ext_clk_in = ~ext_clk_in;

    serial_rx_fifo u_serial_rx_fifo (
        .clk(clk), .rst(rst), .cfg_len7(cfg_len7), .cfg_stop2(cfg_stop2),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_ext_clk(cfg_ext_clk),
        .cfg_baud_div(cfg_baud_div), .ext_clk_in(ext_clk_in), .rxd_in(rxd_in),
        .rd_pop(rd_pop), .flag_clr(flag_clr), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rd_valid(rd_valid), .rd_count(rd_count),
        .ovr_flag(ovr_flag), .brk_flag(brk_flag), .rxd_level(rxd_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_data(input logic [7:0] d, input logic len7);
        return len7 ? {1'b0, d[6:0]} : d;
    endfunction

    function automatic logic good_pbit(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic set_cfg(input logic l7, input logic s2, input logic pe, input logic po,
                           input logic ext, input logic [15:0] div);
        @(negedge clk);
        cfg_len7 = l7; cfg_stop2 = s2; cfg_par_en = pe; cfg_par_odd = po;
        cfg_ext_clk = ext; cfg_baud_div = div;
        bit_clks = ext ? 64 : (int'(div) + 1) * 16;
    endtask

    task automatic line(input logic v, input int n);
        rxd_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        logic [7:0] dm;
        int nbits;
        dm = mask_data(d, cfg_len7);
        nbits = cfg_len7 ? 7 : 8;
        @(negedge clk);
        line(1'b0, bit_clks);
        for (int i = 0; i < nbits; i++) line(dm[i], bit_clks);
        if (cfg_par_en) line(good_pbit(dm, cfg_par_odd) ^ bad_par, bit_clks);
        if (cfg_stop2) line(1'b1, bit_clks);
        if (bad_stop) begin
            line(1'b0, (bit_clks * 3) / 4);
            line(1'b1, bit_clks / 4);
        end else begin
            line(1'b1, bit_clks);
        end
        line(1'b1, 2 * bit_clks);
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_head(input string req, input logic [7:0] d, input logic pe, input logic fe);
        chk({req, " head valid"}, {31'd0, rd_valid}, 32'd1);
        chk({req, " head entry"}, {22'd0, rd_data, rd_perr, rd_ferr}, {22'd0, d, pe, fe});
        pop();
    endtask

    initial begin : main
        logic [7:0] d;
        logic bp, bs, ext;
        logic [15:0] div;
        int guard;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 empty", {27'd0, rd_count}, 32'd0);
        chk("R10 valid", {31'd0, rd_valid}, 32'd0);
        chk("R10 flags", {30'd0, ovr_flag, brk_flag}, 32'd0);
        chk("R10 level", {31'd0, rxd_level}, 32'd1);

        // R1 R2 R3 directed formats
        set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd0);
        send_frame(8'hA5, 1'b0, 1'b0);
        check_head("R1 8E1", 8'hA5, 1'b0, 1'b0);
        set_cfg(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd1);
        send_frame(8'hC3, 1'b0, 1'b0);
        check_head("R1 7O2 msb zero", 8'h43, 1'b0, 1'b0);
        send_frame(8'h3C, 1'b1, 1'b0);
        check_head("R2 odd parity error", 8'h3C, 1'b1, 1'b0);
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0);
        send_frame(8'h81, 1'b0, 1'b1);
        check_head("R3 stop low", 8'h81, 1'b0, 1'b1);

        // R4 short low pulse
        line(1'b0, 5);
        line(1'b1, 3 * bit_clks);
        chk("R4 glitch ignored", {27'd0, rd_count}, 32'd0);

        // R5 pop when empty
        pop();
        chk("R5 pop on empty", {27'd0, rd_count}, 32'd0);

        // R8 line level
        line(1'b0, 3);
        chk("R8 level low", {31'd0, rxd_level}, 32'd0);
        line(1'b1, 3 * bit_clks);
        chk("R8 level high", {31'd0, rxd_level}, 32'd1);
        chk("R4 R8 no entry from short low", {27'd0, rd_count}, 32'd0);

        // Random formats, dividers and clock sources (R1 R2 R3 R9)
        for (int n = 0; n < 40; n++) begin
            ext = ($urandom % 4) == 0;
            case ($urandom % 3)
                0: div = 16'd0;
                1: div = 16'd1;
                default: div = 16'd3;
            endcase
            set_cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, ext, div);
            d  = 8'($urandom);
            bp = cfg_par_en && (($urandom % 4) == 0);
            bs = ($urandom % 6) == 0;
            if (bs) d[0] = 1'b1;
            send_frame(d, bp, bs);
            check_head(ext ? "R9 ext clock frame" : "R9 R1 R2 R3 random frame",
                       mask_data(d, cfg_len7), bp, bs);
            chk("R5 empty after pop", {27'd0, rd_count}, 32'd0);
        end
        chk("R7 no break from isolated errors", {31'd0, brk_flag}, 32'd0);

        // R6 overrun
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0);
        for (int i = 0; i < 17; i++) send_frame(8'h10 + 8'(i), 1'b0, 1'b0);
        chk("R6 count held at 16", {27'd0, rd_count}, 32'd16);
        chk("R6 overrun set", {31'd0, ovr_flag}, 32'd1);
        for (int i = 0; i < 16; i++) check_head("R6 R5 order kept", 8'h10 + 8'(i), 1'b0, 1'b0);
        chk("R6 extra discarded", {31'd0, rd_valid}, 32'd0);
        chk("R6 overrun sticky", {31'd0, ovr_flag}, 32'd1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R6 overrun cleared", {31'd0, ovr_flag}, 32'd0);

        // R7 framing error then good frame: no break
        send_frame(8'h5A, 1'b0, 1'b1);
        send_frame(8'h00, 1'b0, 1'b0);
        check_head("R7 first ferr", 8'h5A, 1'b0, 1'b1);
        check_head("R7 good zero frame", 8'h00, 1'b0, 0);
        chk("R7 no break after good frame", {31'd0, brk_flag}, 32'd0);

        // R7 framing error then sustained low line
        @(negedge clk);
        line(1'b0, bit_clks);
        d = 8'h5A;
        for (int i = 0; i < 8; i++) line(d[i], bit_clks);
        line(1'b0, 30 * bit_clks);
        chk("R8 level during break", {31'd0, rxd_level}, 32'd0);
        line(1'b1, 12 * bit_clks);
        chk("R7 break set", {31'd0, brk_flag}, 32'd1);
        check_head("R7 break lead frame", 8'h5A, 1'b0, 1'b1);
        chk("R7 all-low frames framed", {31'd0, rd_data == 8'h00 && rd_ferr}, 32'd1);
        guard = 0;
        while (rd_valid && guard < 20) begin
            pop();
            guard++;
        end
        chk("R7 break sticky", {31'd0, brk_flag}, 32'd1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R7 break cleared", {31'd0, brk_flag}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule